// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial EEPROM. The host presents a word address, a width-select bit and a one-cycle start strobe. The block then asserts chip select. It shifts out the read opcode and the address on the serial data output, one bit per serial clock. After that it clocks sixteen data bits back in from the memory's serial output. When the transfer ends it releases chip select and raises a one-cycle done pulse. The assembled word is valid on the result port in that same cycle.

The serial clock is produced from the system clock. Each low phase and each high phase of the serial clock lasts `PHASE_CYC` system cycles, so slow memories can be met by raising that parameter. The width-select input picks the address width for each transfer. With it low the block sends a 6-bit address. With it high it sends an 8-bit address. The data word follows the last command bit with no dummy or turnaround bit in between.

Top module: `mw_word_reader`

## Requirements
- R1: After a synchronous reset, and whenever no transfer is running, `cs_o`, `sk_o`, `di_o`, `busy_o` and `done_o` are all low.
- R2: A `start_i` high while idle is taken at that clock edge. From the next cycle `cs_o` and `busy_o` are high. The block then holds one phase with `sk_o` and `di_o` low before the first command bit.
- R3: The command frame is the opcode bits 1,1,0 followed by the address, most significant bit first. With `wide_i` low it is 9 bits and carries `addr_i[5:0]`. With `wide_i` high it is 11 bits and carries `addr_i[7:0]`.
- R4: Each command bit is placed on `di_o` for one low phase of `sk_o` and then held through one high phase. Every phase lasts exactly `PHASE_CYC` cycles, and `di_o` only changes while `sk_o` is low.
- R5: After the last command bit, `sk_o` stays low and `di_o` is low for one phase before readback.
- R6: Readback is 16 pairs of a high phase followed by a low phase. `sdi_i` is sampled at the last cycle of each high phase and shifted into the result LSB, so the first bit read becomes bit 15.
- R7: After the last low phase, `cs_o` drops while `sk_o` stays low, for one phase. In the next cycle `done_o` is high for exactly one cycle, with `busy_o` low and `data_o` holding the word.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. Neither the frame sent nor the word returned changes.
- R9: `busy_o` is high from the cycle after a start is taken until the cycle before `done_o`. A start given in the `done_o` cycle is taken.
- R10: A reset asserted in the middle of a transfer returns all serial outputs and `busy_o` low on the next cycle, and a later transfer runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a read when idle |
| wide_i | input | 1 | 1 selects 8-bit address, 0 selects 6-bit |
| addr_i | input | ADDR_W | Word address |
| sdi_i | input | 1 | Serial data from the memory |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DATA_W | Word read back |

## Verification
The bench runs a behavioural memory model. It decodes the opcode and the address from the serial pins and returns a word computed from that address. The hardest situations to reach from the ports are timing edges: a second start landing mid-frame, a start landing exactly in the done cycle, and a reset cutting a readback short. The stimulus holds start through the done cycle to force immediate reacceptance. It also pulses start deep inside a transfer with a different address and width. Finally it asserts reset a hundred cycles into a frame and then runs a clean transfer.

// File: rtl/mw_rd_pkg.sv
`timescale 1ns/1ps
package mw_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_CMD   = 3'd2,
        ST_GAP   = 3'd3,
        ST_READ  = 3'd4,
        ST_DESEL = 3'd5
    } mw_state_e;

    localparam int          MW_OP_W    = 3;
    localparam logic [2:0]  MW_OP_READ = 3'b110;
endpackage

// File: rtl/mw_phase_timer.sv
`timescale 1ns/1ps
// Counts system cycles inside one serial clock phase.
module mw_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_end
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        phase_end = run && (cnt_q == CNT_W'(PHASE_CYC - 1));
        if (!run || phase_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mw_cmd_frame.sv
`timescale 1ns/1ps
// Builds the left-justified read command and its length.
module mw_cmd_frame
    import mw_rd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SHORT_W = 6,
    parameter int LEN_W   = 5
) (
    input  logic                        wide,
    input  logic [ADDR_W-1:0]           addr,
    output logic [MW_OP_W+ADDR_W-1:0]   frame,
    output logic [LEN_W-1:0]            frame_len
);
    localparam int FRAME_W = MW_OP_W + ADDR_W;
    localparam int PAD_W   = ADDR_W - SHORT_W;

    logic [FRAME_W-1:0] short_frame;

    generate
        if (PAD_W > 0) begin : g_pad
            assign short_frame = {MW_OP_READ, addr[SHORT_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign short_frame = {MW_OP_READ, addr};
        end
    endgenerate

    always_comb begin
        if (wide) begin
            frame     = {MW_OP_READ, addr};
            frame_len = LEN_W'(FRAME_W);
        end else begin
            frame     = short_frame;
            frame_len = LEN_W'(MW_OP_W + SHORT_W);
        end
    end
endmodule

// File: rtl/mw_rx_shift.sv
`timescale 1ns/1ps
// Collects readback bits, MSB first, shifting into the LSB.
module mw_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (clr) begin
            word_d = '0;
        end else if (shift) begin
            word_d = {word_q[DATA_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/mw_word_reader.sv
`timescale 1ns/1ps
module mw_word_reader
    import mw_rd_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int ADDR_W    = 8,
    parameter int SHORT_W   = 6,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sdi_i,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int FRAME_W = MW_OP_W + ADDR_W;
    localparam int MAXCNT  = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
    localparam int CNT_W   = $clog2(MAXCNT + 1);

    typedef struct packed {
        mw_state_e          st;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
        logic               hi;
        logic               cs;
        logic               sk;
        logic               di;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               phase_end;
    logic               rx_clr;
    logic               rx_shift;
    logic [FRAME_W-1:0] new_frame;
    logic [CNT_W-1:0]   new_len;

    mw_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (busy_o),
        .phase_end (phase_end)
    );

    mw_cmd_frame #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LEN_W(CNT_W)) u_frame (
        .wide      (wide_i),
        .addr      (addr_i),
        .frame     (new_frame),
        .frame_len (new_len)
    );

    mw_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clr    (rx_clr),
        .shift  (rx_shift),
        .bit_in (sdi_i),
        .word   (data_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        rx_clr     = 1'b0;
        rx_shift   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_SEL;
                    ctl_d.frame = new_frame;
                    ctl_d.left  = new_len;
                    ctl_d.hi    = 1'b0;
                    ctl_d.cs    = 1'b1;
                    ctl_d.sk    = 1'b0;
                    ctl_d.di    = 1'b0;
                    rx_clr      = 1'b1;
                end
            end
            ST_SEL: begin
                if (phase_end) begin
                    ctl_d.st = ST_CMD;
                    ctl_d.hi = 1'b0;
                    ctl_d.di = ctl_q.frame[FRAME_W-1];
                end
            end
            ST_CMD: begin
                if (phase_end) begin
                    if (!ctl_q.hi) begin
                        ctl_d.hi = 1'b1;
                        ctl_d.sk = 1'b1;
                    end else begin
                        ctl_d.hi    = 1'b0;
                        ctl_d.sk    = 1'b0;
                        ctl_d.frame = ctl_q.frame << 1;
                        ctl_d.left  = ctl_q.left - 1'b1;
                        if (ctl_q.left == CNT_W'(1)) begin
                            ctl_d.st = ST_GAP;
                            ctl_d.di = 1'b0;
                        end else begin
                            ctl_d.di = ctl_q.frame[FRAME_W-2];
                        end
                    end
                end
            end
            ST_GAP: begin
                if (phase_end) begin
                    ctl_d.st   = ST_READ;
                    ctl_d.hi   = 1'b1;
                    ctl_d.sk   = 1'b1;
                    ctl_d.left = CNT_W'(DATA_W);
                end
            end
            ST_READ: begin
                if (phase_end) begin
                    if (ctl_q.hi) begin
                        rx_shift = 1'b1;
                        ctl_d.hi = 1'b0;
                        ctl_d.sk = 1'b0;
                    end else begin
                        ctl_d.left = ctl_q.left - 1'b1;
                        if (ctl_q.left == CNT_W'(1)) begin
                            ctl_d.st = ST_DESEL;
                            ctl_d.cs = 1'b0;
                        end else begin
                            ctl_d.hi = 1'b1;
                            ctl_d.sk = 1'b1;
                        end
                    end
                end
            end
            ST_DESEL: begin
                if (phase_end) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: begin
                ctl_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cs_o   = ctl_q.cs;
    assign sk_o   = ctl_q.sk;
    assign di_o   = ctl_q.di;
    assign done_o = ctl_q.done;
    assign busy_o = (ctl_q.st != ST_IDLE);
endmodule

module mw_word_reader_chk #(
    parameter int PHASE_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic cs_o,
    input logic sk_o,
    input logic di_o,
    input logic busy_o,
    input logic done_o
);
    int hi_run;

    always_ff @(posedge clk) begin
        if (rst || !sk_o) begin
            hi_run <= 0;
        end else begin
            hi_run <= hi_run + 1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_o |-> (!sk_o && !di_o));

    // R9
    cs_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cs_o |-> busy_o);

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_released_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !cs_o));

    // R4
    di_low_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(di_o) |-> !sk_o);

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sk_o) |-> (hi_run == PHASE_CYC));
endmodule

bind mw_word_reader mw_word_reader_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cs_o    (cs_o),
    .sk_o    (sk_o),
    .di_o    (di_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/mw_word_reader_test.sv
`timescale 1ns/1ps
module mw_word_reader_test;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        wide;
    logic [7:0]  addr;
    logic        sdi = 1'b0;
    logic        cs, sk, di, busy, done;
    logic [15:0] data;

    int vectors = 0;
    int bad     = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mw_word_reader uut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .wide_i  (wide),
        .addr_i  (addr),
        .sdi_i   (sdi),
        .cs_o    (cs),
        .sk_o    (sk),
        .di_o    (di),
        .busy_o  (busy),
        .done_o  (done),
        .data_o  (data)
    );

    // expected {cs, sk, di, busy, done} per cycle
    logic [4:0]  exp_q[$];
    string       tag_q[$];
    logic [15:0] word_q[$];
    logic        cur_mode = 1'b0;
    bit          rst_abort = 0;
    bit          ign_seen = 0;

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return 16'({8'h00, a} * 16'h9E37) ^ 16'hC3A5;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push_n(input logic [4:0] v, input string t);
        for (int i = 0; i < P; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    task automatic enqueue(input logic m, input logic [7:0] a);
        logic bits[$];
        int   aw;
        aw = m ? 8 : 6;
        bits.push_back(1'b1);
        bits.push_back(1'b1);
        bits.push_back(1'b0);
        for (int i = aw - 1; i >= 0; i--) bits.push_back(a[i]);
        push_n(5'b10010, "R2,R9");
        foreach (bits[i]) begin
            push_n({1'b1, 1'b0, bits[i], 1'b1, 1'b0}, "R3,R4");
            push_n({1'b1, 1'b1, bits[i], 1'b1, 1'b0}, "R3,R4");
        end
        push_n(5'b10010, "R5");
        for (int k = 0; k < 16; k++) begin
            push_n(5'b11010, "R6");
            push_n(5'b10010, "R6");
        end
        push_n(5'b00010, "R7,R9");
        exp_q.push_back(5'b00001);
        tag_q.push_back("R7");
        word_q.push_back(mem_word(m ? a : {2'b00, a[5:0]}));
        cur_mode  = m;
        rst_abort = 0;
    endtask

    task automatic step(input logic r, input logic s, input logic m, input logic [7:0] a);
        logic [4:0]  e;
        logic [4:0]  got;
        logic [15:0] w;
        string       t;
        bit          idle_now;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = 5'b00000;
            t = rst_abort ? "R10" : "R1";
        end
        got = {cs, sk, di, busy, done};
        chk(got === e, t, int'(got), int'(e));
        if (e[0]) begin
            w = word_q.pop_front();
            chk(data === w, ign_seen ? "R8" : "R6", int'(data), int'(w));
            ign_seen = 0;
        end
        idle_now = !e[1];
        rst   = r;
        start = s;
        wide  = m;
        addr  = a;
        if (r) begin
            if (exp_q.size() > 0) rst_abort = 1;
            exp_q.delete();
            tag_q.delete();
            word_q.delete();
            ign_seen = 0;
        end else if (s && idle_now) begin
            enqueue(m, a);
        end else if (s) begin
            ign_seen = 1;
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic xfer(input logic m, input logic [7:0] a);
        step(1'b0, 1'b1, m, a);
        drain();
    endtask

    // behavioural memory: decodes the frame from the pins, answers MSB first
    int          ee_cnt = 0;
    int          ee_len = 9;
    bit          ee_act = 0;
    logic [10:0] ee_sh = '0;
    logic [15:0] ee_word = '0;

    always @(posedge sk or cs) begin
        if (!cs) begin
            ee_act = 0;
        end else if (!ee_act) begin
            ee_act = 1;
            ee_cnt = 0;
            ee_sh  = '0;
            sdi    = 1'b0;
            ee_len = cur_mode ? 11 : 9;
        end else if (sk) begin
            if (ee_cnt < ee_len) begin
                ee_sh = {ee_sh[9:0], di};
                ee_cnt++;
                if (ee_cnt == ee_len) begin
                    chk(ee_sh[ee_len-1 -: 3] == 3'b110, "R3",
                        int'(ee_sh[ee_len-1 -: 3]), 6);
                    ee_word = mem_word(cur_mode ? ee_sh[7:0] : {2'b00, ee_sh[5:0]});
                end
            end else begin
                if (ee_cnt - ee_len < 16) sdi = ee_word[15 - (ee_cnt - ee_len)];
                else sdi = 1'b0;
                ee_cnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; wide = 1'b0; addr = 8'h00;
        repeat (3) step(1'b1, 1'b0, 1'b0, 8'h00);
        // R1: reset state and idle
        repeat (3) step(1'b0, 1'b0, 1'b0, 8'h00);
        // R3: both address widths, bit patterns at the extremes
        xfer(1'b1, 8'hA5);
        xfer(1'b0, 8'hFF);
        xfer(1'b1, 8'h00);
        xfer(1'b0, 8'h2A);
        xfer(1'b1, 8'hFF);
        xfer(1'b0, 8'hC0);
        // R8: starts during a running transfer are ignored
        step(1'b0, 1'b1, 1'b1, 8'h3C);
        repeat (60) step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 1'b0, 8'h11);
        step(1'b0, 1'b1, 1'b0, 8'h11);
        repeat (90) step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 1'b1, 8'h99);
        drain();
        // R9: a start in the done cycle is taken
        step(1'b0, 1'b1, 1'b0, 8'h15);
        while (exp_q.size() > 1) step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 1'b1, 8'hC7);
        drain();
        // R10: reset in the middle of a transfer
        step(1'b0, 1'b1, 1'b1, 8'h5A);
        repeat (100) step(1'b0, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 1'b0, 8'h00);
        repeat (3) step(1'b0, 1'b0, 1'b0, 8'h00);
        xfer(1'b0, 8'h07);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end
endmodule